// File: doc/BRIEF.md
# SPI Master with Selectable Late Capture

This block is a single-lane SPI master. It produces the serial clock from the system clock, shifts a byte out on MOSI most significant bit first, and collects a byte from MISO in the same frame. The serial clock idles low. MOSI changes only on falling serial-clock edges, so the target samples MOSI on rising edges. The SCK half-period is a programmable whole number of system clocks.

A mode input chooses how the master captures MISO. In standard capture, MISO is taken on the rising edge, as in ordinary mode 0. In that case the target's clock-to-output delay plus the wire round trip must fit within half an SCK period. In late capture, MISO is taken on the falling edge, which is the same edge that launches the next MOSI bit. This gives the return path a full SCK period, so a slow or distant target can run at about twice the SCK rate. The master captures before the target's output changes after that falling edge. In late capture, one additional half-period is held after the last falling edge before chip select is released.

Software pulses `start` with the byte, the mode and the divider applied. The block samples all three at that cycle. It then raises `busy` and runs the frame. When chip select rises, a one-cycle `done` pulse marks `rx_byte` as valid.

Top module: `spi_late_master`

## Requirements
- R1: Outside a frame, `sck` is low, `cs_n` is high and `busy` is low. `sck` is never high while `cs_n` is high.
- R2: `cs_n` falls in the cycle after `start` is sampled, and the first rising `sck` edge follows H system clocks later. H is the effective half-period.
- R3: MOSI carries `tx_byte` most significant bit first. It changes only when `sck` falls or when `cs_n` falls, so it is stable at every rising edge.
- R4: Each frame has exactly 8 rising `sck` edges, and every `sck` level lasts H system clocks. `done` arrives (17+L)*H+1 cycles after the cycle in which `start` is driven, where L is 1 in late capture and 0 otherwise.
- R5: With `late_mode`=0, MISO is captured on rising `sck` edges. A target whose output changes more than H-1 system clocks after a falling edge is therefore read one bit late.
- R6: With `late_mode`=1, MISO is captured on falling `sck` edges. A target whose output changes up to 2H-1 system clocks after a falling edge is read correctly.
- R7: `cs_n` rises H system clocks after the last falling `sck` edge in standard capture, and 2H system clocks after it in late capture.
- R8: `done` is a one-cycle pulse in the cycle `cs_n` rises. `rx_byte` then holds the received byte, first received bit in bit 7.
- R9: While `busy` is high, the inputs `start`, `tx_byte`, `late_mode` and `half_div` have no effect on the running frame. A `start` pulse during a frame does not queue a new one.
- R10: The effective half-period H is `half_div`, except that a value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame when idle |
| tx_byte | input | 8 | Byte to transmit, sampled at start |
| late_mode | input | 1 | 1 = capture MISO on falling SCK, 0 = on rising SCK |
| half_div | input | 8 | SCK half-period in system clocks (0 acts as 1) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| rx_byte | output | 8 | Received byte, valid at done |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to produce is a target that is too slow for standard capture but still fast enough for late capture. The bench models the target with an explicit output delay, counted in system clocks after each falling SCK edge. At 2H-1 clocks of delay, late capture must return the exact byte. Standard capture at the same delay must return the byte shifted by one bit, with its first bit repeated. Separately, a start pulse, a new byte, the other mode and a different divider are all applied mid-frame. The frame's edge timing and data must stay those latched at start.

// File: rtl/spi_lm_pkg.sv
package spi_lm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CLK,
        ST_TAIL
    } spi_st_e;
endpackage

// File: rtl/spi_lm_tick.sv
// Half-period timer: emits one tick every HALF system clocks while run is high.
module spi_lm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == half - {{(DIV_W-1){1'b0}}, 1'b1});

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the counter never runs past the programmed half-period
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < half));
endmodule

// File: rtl/spi_lm_shift.sv
// Transmit and receive shift registers, MSB first.
module spi_lm_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              adv_tx,
    input  logic              cap,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx
);
    logic [DATA_W-1:0] tx_d, tx_q, rx_d, rx_q;

    always_comb begin
        tx_d = tx_q;
        rx_d = rx_q;
        if (load)        tx_d = load_val;
        else if (adv_tx) tx_d = {tx_q[DATA_W-2:0], 1'b0};
        if (cap)         rx_d = {rx_q[DATA_W-2:0], miso};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign mosi = tx_q[DATA_W-1];
    assign rx   = rx_q;
endmodule

// File: rtl/spi_late_master.sv
// SPI master, clock idle low, MOSI launched on falling SCK, MISO captured on
// rising SCK (standard) or on falling SCK (late capture).
module spi_late_master
    import spi_lm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              late_mode,
    input  logic [DIV_W-1:0]  half_div,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
    localparam logic [DIV_W-1:0] ONE_DIV  = {{(DIV_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        spi_st_e          st;
        logic             sck;
        logic             cs_n;
        logic             late;
        logic [DIV_W-1:0] half;
        logic [BIT_W-1:0] bitn;
        logic             tail_more;
        logic             done;
    } ctl_t;

    ctl_t c_d, c_q;
    logic tick, load, adv_tx, cap;

    spi_lm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (c_q.st != ST_IDLE),
        .half  (c_q.half),
        .tick  (tick)
    );

    spi_lm_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (tx_byte),
        .adv_tx   (adv_tx),
        .cap      (cap),
        .miso     (miso),
        .mosi     (mosi),
        .rx       (rx_byte)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        load     = 1'b0;
        adv_tx   = 1'b0;
        cap      = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st        = ST_LEAD;
                    c_d.cs_n      = 1'b0;
                    c_d.late      = late_mode;
                    c_d.half      = (half_div == '0) ? ONE_DIV : half_div;
                    c_d.bitn      = '0;
                    c_d.tail_more = 1'b0;
                    load          = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    c_d.st  = ST_CLK;
                    c_d.sck = 1'b1;
                    cap     = !c_q.late;
                end
            end
            ST_CLK: begin
                if (tick) begin
                    if (!c_q.sck) begin
                        c_d.sck = 1'b1;
                        cap     = !c_q.late;
                    end else begin
                        c_d.sck = 1'b0;
                        cap     = c_q.late;
                        if (c_q.bitn == LAST_BIT) begin
                            c_d.st        = ST_TAIL;
                            c_d.tail_more = c_q.late;
                        end else begin
                            c_d.bitn = c_q.bitn + 1'b1;
                            adv_tx   = 1'b1;
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    if (c_q.tail_more) begin
                        c_d.tail_more = 1'b0;
                    end else begin
                        c_d.st   = ST_IDLE;
                        c_d.cs_n = 1'b1;
                        c_d.done = 1'b1;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= ST_IDLE;
            c_q.cs_n <= 1'b1;
            c_q.half <= ONE_DIV;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy = (c_q.st != ST_IDLE);
    assign done = c_q.done;
    assign sck  = c_q.sck;
    assign cs_n = c_q.cs_n;

    // R1: lines at rest outside a frame
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sck && cs_n));
    // R1: clock only pulses inside chip select
    p_sck_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);
    // R3: MOSI only moves on a falling SCK edge within a frame
    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$fell(sck)) |-> $stable(mosi));
    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: done coincides with chip select release
    p_done_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);
endmodule

// File: tb/tb_spi_late_master.sv
module tb_spi_late_master;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       late_mode = 1'b0;
    logic [7:0] half_div = 8'd1;
    logic       busy, done, sck, cs_n, mosi;
    logic       miso = 1'b0;
    logic [7:0] rx_byte;

    int nchk = 0, nerr = 0;
    int cyc = 0;
    int t_st, t_csf, t_r1, t_fl, t_csr, t_done, rises;
    logic sck_p = 1'b0, cs_p = 1'b1;
    logic [7:0] got;

    always #(CLK_NS/2) clk = ~clk;

    spi_late_master dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
        .late_mode(late_mode), .half_div(half_div), .busy(busy), .done(done),
        .rx_byte(rx_byte), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cs_p && !cs_n) t_csf = cyc;
        if (!sck_p && sck) begin
            rises = rises + 1;
            if (rises == 1) t_r1 = cyc;
        end
        if (sck_p && !sck) t_fl = cyc;
        if (!cs_p && cs_n) t_csr = cyc;
        if (done) t_done = cyc;
        sck_p = sck;
        cs_p  = cs_n;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] rxp, input logic lm,
                        input logic [7:0] hd, input int dly, input logic [7:0] exp_rx,
                        input bit disturb);
        int h;
        h = (hd == 0) ? 1 : int'(hd);
        @(negedge clk);
        miso = rxp[7]; tx_byte = tx; late_mode = lm; half_div = hd;
        start = 1'b1; rises = 0; t_st = cyc;
        @(negedge clk);
        start = 1'b0;
        fork
            begin
                for (int i = 6; i >= 0; i--) begin
                    @(negedge sck);
                    repeat (dly) @(posedge clk);
                    #1 miso = rxp[i];
                end
            end
            begin
                got = '0;
                for (int i = 0; i < 8; i++) begin
                    @(posedge sck);
                    got = {got[6:0], mosi};
                end
            end
            begin
                if (disturb) begin
                    repeat (3) @(negedge clk);
                    start = 1'b1; tx_byte = ~tx; late_mode = ~lm; half_div = hd + 8'd3;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
            begin
                do @(negedge clk); while (!done);
            end
        join
        #1;
        chk(lm ? "R6 rx byte (late capture)" : "R5 rx byte (standard capture)",
            int'(rx_byte), int'(exp_rx));
        chk("R3 mosi MSB first", int'(got), int'(tx));
        chk("R2 cs to first rise", t_r1 - t_csf, h);
        chk("R4 rising edge count", rises, 8);
        chk("R4 R10 frame length", t_done - t_st, 1 + (17 + int'(lm)) * h);
        chk("R7 tail before cs release", t_csr - t_fl, (lm ? 2 : 1) * h);
        chk("R8 done with cs rise", t_csr, t_done);
        @(negedge clk);
        chk("R8 done single cycle", int'(done), 0);
        @(negedge clk);
        chk("R9 no queued frame", int'({busy, cs_n}), 1);
    endtask

    function automatic logic [7:0] pat(input int k);
        case (k)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'hA5;
            3: return 8'h5A;
            4: return 8'h01;
            default: return 8'h80;
        endcase
    endfunction

    initial begin
        #(CLK_NS * 150000);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] tx, rxp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset sck", int'(sck), 0);
        chk("R1 reset cs_n", int'(cs_n), 1);
        chk("R1 reset busy", int'(busy), 0);
        chk("R8 reset done", int'(done), 0);

        // Sweep: divider, capture mode and data patterns, target at its slowest legal delay
        for (int h = 1; h <= 3; h++) begin
            for (int m = 0; m < 2; m++) begin
                for (int k = 0; k < 6; k++) begin
                    tx  = pat(k);
                    rxp = 8'hC3 ^ {tx[3:0], tx[7:4]};
                    xfer(tx, rxp, m[0], 8'(h), (m == 1) ? 2*h - 1 : h - 1, rxp, 1'b0);
                end
            end
        end

        // R5: a target slower than half a period is read one bit late in standard capture
        for (int h = 1; h <= 2; h++) begin
            rxp = 8'h96;
            xfer(8'h3C, rxp, 1'b0, 8'(h), 2*h - 1, {rxp[7], rxp[7:1]}, 1'b0);
        end
        // R6: the same target is read correctly with late capture, zero delay too
        xfer(8'h3C, 8'h96, 1'b1, 8'd2, 3, 8'h96, 1'b0);
        xfer(8'hE1, 8'h4B, 1'b1, 8'd1, 0, 8'h4B, 1'b0);

        // R10: a divider of zero behaves as one
        xfer(8'h69, 8'hD2, 1'b0, 8'd0, 0, 8'hD2, 1'b0);
        xfer(8'h69, 8'hD2, 1'b1, 8'd0, 1, 8'hD2, 1'b0);

        // R9: inputs changed and start pulsed mid-frame have no effect
        xfer(8'hB4, 8'h2D, 1'b1, 8'd2, 3, 8'h2D, 1'b1);
        xfer(8'h4B, 8'hF0, 1'b0, 8'd3, 2, 8'hF0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule